// File: doc/BRIEF.md
# Root Port Legacy Interrupt Event Queue

This block collects legacy INTx assert and deassert events that downstream devices send to a PCIe root port and holds them in a small circular queue until software drains them. Each accepted event raises a pending bit in a decode register. That bit is ANDed with a software mask to drive one level-sensitive interrupt line. Software reads the oldest event through two head registers and retires it by writing to either of them. If an event arrives while the queue is full, it is dropped and a sticky overflow flag records the loss.

The register port is a plain 32-bit write port with a word address. Reads are combinational from the address and have no side effects. The block also reports link state from an input pin and holds a bridge-enable control bit that drives an output.

Top module: `rp_intq`

## Requirements
- R1: After a synchronous active-low reset, every mapped register reads zero except the link bit, `irq` and `bridge_en` are 0, and the queue is empty.
- R2: The mask register at word address 0x4F stores all 32 written bits and reads them back.
- R3: The head word at 0x56 reads bit 31 = 1, bit 30 = 0, bit 29 = the assert level, bits 28:27 = the lane, and bits 26:0 = 0. The second head word at 0x57 always reads 0. Both read 0 when the queue is empty.
- R4: Events leave the queue in arrival order. A write of any data to 0x56 or 0x57 retires the head entry. Such a write to an empty queue changes nothing.
- R5: The queue holds DEPTH-1 entries, which is 7 by default. An event that arrives while the queue is full is discarded, even if a pop happens in the same cycle, and sets the overflow flag at bit 19 of 0x52. The flag stays set until a write to 0x52 with bit 19 = 1. If that clearing write and an overflow happen in the same cycle, the flag stays set.
- R6: Bit 18 of 0x52 reads 1 exactly when the queue holds at least one entry.
- R7: Bit 16 of 0x4E is the INTx pending bit. An accepted event sets it. Writing 1 to bit 16 clears it, but only if the queue will be empty after that cycle. Once the queue drains, the bit stays 1 until software clears it. Every other bit of 0x4E reads 0.
- R8: `irq` equals the pending bit ANDed with mask bit 16.
- R9: Bit 0 of 0x52 is a read/write bridge enable that drives `bridge_en`. Writes to 0x52 change no other stored state, apart from the overflow clear in R5.
- R10: Bit 11 of 0x51 reflects `link_up`, and every other bit of 0x51 reads 0.
- R11: Unmapped word addresses read 0, and writes to them change nothing.
- R12: An accepted event and a pop in the same cycle both take effect, so the entry count stays the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 8 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_valid | input | 1 | An INTx event is presented this cycle |
| evt_lane | input | 2 | INTx lane of the event (A..D as 0..3) |
| evt_level | input | 1 | 1 = assert, 0 = deassert |
| link_up | input | 1 | Link state from the physical layer |
| irq | output | 1 | Level interrupt request |
| bridge_en | output | 1 | Bridge enable control |

## Verification
The assertions assume that `evt_valid`, `bus_wr_en` and their qualifiers are stable and free of X around the rising edge. They also assume that at most one event is offered per cycle and that each event is either accepted or dropped in that same cycle, because there is no backpressure. The bench drives every input on the falling edge and samples half a period later. It overfills the queue deliberately to reach the overflow path and combines pops with new events in one cycle. It never offers more than one event per cycle.

// File: rtl/rp_intq_pkg.sv
// Package: shared constants and types for the root port interrupt queue.
// Assumes a word-addressed 32-bit register port.
package rp_intq_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned LANE_W = 2;

    // word addresses
    localparam logic [ADDR_W-1:0] A_DECODE = 8'h4E;
    localparam logic [ADDR_W-1:0] A_MASK   = 8'h4F;
    localparam logic [ADDR_W-1:0] A_PHY    = 8'h51;
    localparam logic [ADDR_W-1:0] A_CTRL   = 8'h52;
    localparam logic [ADDR_W-1:0] A_HEAD0  = 8'h56;
    localparam logic [ADDR_W-1:0] A_HEAD1  = 8'h57;

    // bit positions
    localparam int unsigned B_INTX   = 16;
    localparam int unsigned B_LINK   = 11;
    localparam int unsigned B_BREN   = 0;
    localparam int unsigned B_NEMPTY = 18;
    localparam int unsigned B_OVF    = 19;
    localparam int unsigned B_VALID  = 31;
    localparam int unsigned B_LEVEL  = 29;
    localparam int unsigned B_LANE   = 27;

    typedef struct packed {
        logic              level;
        logic [LANE_W-1:0] lane;
    } intx_evt_t;
endpackage

// File: rtl/rp_intq_fifo.sv
// Module: circular event store with one slot always unused.
// Assumes DEPTH >= 2; a push when full is refused, a pop when empty is refused.
module rp_intq_fifo
    import rp_intq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  intx_evt_t        push_evt,
    input  logic             pop,
    output logic             push_ok,
    output logic             pop_ok,
    output intx_evt_t        head,
    output logic             empty,
    output logic             one_left,
    output logic [CNT_W-1:0] count,
    output logic [PTR_W-1:0] rd_ptr
);
    intx_evt_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic full;
    assign full     = (step(wr_ptr) == rd_ptr);
    assign empty    = (wr_ptr == rd_ptr);
    assign push_ok  = push & ~full;
    assign pop_ok   = pop & ~empty;
    assign head     = mem[rd_ptr];
    assign one_left = (count == CNT_W'(1));

    // Occupancy derived from the pointer distance.
    always_comb begin
        if (wr_ptr >= rd_ptr) count = CNT_W'(wr_ptr - rd_ptr);
        else                  count = CNT_W'(DEPTH) - CNT_W'(rd_ptr) + CNT_W'(wr_ptr);
    end

    // Pointer advance on accepted push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push_ok) wr_ptr <= step(wr_ptr);
            if (pop_ok)  rd_ptr <= step(rd_ptr);
        end
    end

    // Entry storage; contents are only read while non-empty.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_evt;
    end
endmodule

// File: rtl/rp_intq_regs.sv
// Module: register file, pending/mask logic and read mux.
// Assumes fifo status inputs describe the state before the current edge.
module rp_intq_regs
    import rp_intq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              link_up,
    input  logic              evt_valid,
    input  logic              q_push_ok,
    input  logic              q_pop_ok,
    input  logic              q_empty,
    input  logic              q_one_left,
    input  intx_evt_t         q_head,
    output logic              pop_req,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              bridge_en,
    output logic              pend_intx,
    output logic              ovf_flag,
    output logic              intx_mask
);
    logic [DATA_W-1:0] mask_q;
    logic              wr_dec, wr_mask, wr_ctrl;
    logic              nonempty_nxt;
    logic [DATA_W-1:0] pend_vec, head_word;

    assign wr_dec   = wr_en && (addr == A_DECODE);
    assign wr_mask  = wr_en && (addr == A_MASK);
    assign wr_ctrl  = wr_en && (addr == A_CTRL);
    assign pop_req  = wr_en && ((addr == A_HEAD0) || (addr == A_HEAD1));
    assign nonempty_nxt = q_push_ok | (~q_empty & ~(q_pop_ok & q_one_left));
    assign intx_mask = mask_q[B_INTX];

    // Pending vector: only the INTx source can be pending.
    always_comb begin
        pend_vec         = '0;
        pend_vec[B_INTX] = pend_intx;
    end
    assign irq = |(pend_vec & mask_q);

    // Stored control state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q    <= '0;
            pend_intx <= 1'b0;
            ovf_flag  <= 1'b0;
            bridge_en <= 1'b0;
        end else begin
            if (wr_mask) mask_q <= wdata;
            pend_intx <= (pend_intx & ~(wr_dec & wdata[B_INTX])) | nonempty_nxt;
            if (evt_valid && !q_push_ok)  ovf_flag <= 1'b1;
            else if (wr_ctrl && wdata[B_OVF]) ovf_flag <= 1'b0;
            if (wr_ctrl) bridge_en <= wdata[B_BREN];
        end
    end

    // Head entry formatted as the first FIFO read word.
    always_comb begin
        head_word                       = '0;
        head_word[B_VALID]              = 1'b1;
        head_word[B_LEVEL]              = q_head.level;
        head_word[B_LANE +: LANE_W]     = q_head.lane;
    end

    // Combinational read mux.
    always_comb begin
        rdata = '0;
        case (addr)
            A_DECODE: rdata = pend_vec;
            A_MASK:   rdata = mask_q;
            A_PHY:    rdata[B_LINK] = link_up;
            A_CTRL: begin
                rdata[B_BREN]   = bridge_en;
                rdata[B_NEMPTY] = ~q_empty;
                rdata[B_OVF]    = ovf_flag;
            end
            A_HEAD0:  rdata = q_empty ? '0 : head_word;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/rp_intq.sv
// Module: top of the root port INTx event queue.
// Assumes one event per cycle at most, and no backpressure on events.
module rp_intq
    import rp_intq_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              evt_valid,
    input  logic [LANE_W-1:0] evt_lane,
    input  logic              evt_level,
    input  logic              link_up,
    output logic              irq,
    output logic              bridge_en
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    intx_evt_t        new_evt, q_head;
    logic             q_push_ok, q_pop_ok, q_empty, q_one_left, pop_req;
    logic [CNT_W-1:0] q_count;
    logic [PTR_W-1:0] rd_ptr;
    logic             pend_intx, ovf_flag, intx_mask;

    assign new_evt.level = evt_level;
    assign new_evt.lane  = evt_lane;

    rp_intq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (evt_valid),
        .push_evt (new_evt),
        .pop      (pop_req),
        .push_ok  (q_push_ok),
        .pop_ok   (q_pop_ok),
        .head     (q_head),
        .empty    (q_empty),
        .one_left (q_one_left),
        .count    (q_count),
        .rd_ptr   (rd_ptr)
    );

    rp_intq_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr_en),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .link_up    (link_up),
        .evt_valid  (evt_valid),
        .q_push_ok  (q_push_ok),
        .q_pop_ok   (q_pop_ok),
        .q_empty    (q_empty),
        .q_one_left (q_one_left),
        .q_head     (q_head),
        .pop_req    (pop_req),
        .rdata      (bus_rdata),
        .irq        (irq),
        .bridge_en  (bridge_en),
        .pend_intx  (pend_intx),
        .ovf_flag   (ovf_flag),
        .intx_mask  (intx_mask)
    );
endmodule

// File: rtl/rp_intq_chk.sv
// Module: property checker for rp_intq, attached by bind below.
// Assumes synchronous active-low reset; all properties are off during reset.
module rp_intq_chk
    import rp_intq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_valid,
    input logic              bus_wr_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic [CNT_W-1:0]  q_count,
    input logic              q_empty,
    input logic [PTR_W-1:0]  rd_ptr,
    input logic              pend_intx,
    input logic              ovf_flag,
    input logic              intx_mask
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH - 1);

    // R7: pending bit is held while entries remain
    a_r7_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count != '0) |-> pend_intx);

    // R5: never more than DEPTH-1 entries
    a_r5_capacity: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CAP);

    // R5: event into a full queue sets the flag
    a_r5_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && q_count == CAP) |=> ovf_flag);

    // R5: flag only drops after a clearing write
    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(bus_wr_en && bus_addr == A_CTRL && bus_wdata[B_OVF])) |=> ovf_flag);

    // R4: pop of an empty queue leaves the read pointer alone
    a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && (bus_addr == A_HEAD0 || bus_addr == A_HEAD1) && q_empty) |=> $stable(rd_ptr));

    // R8: interrupt requires the INTx mask bit
    a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> intx_mask);

    // R12: accepted event plus pop keeps the count
    a_r12_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && q_count != CAP && !q_empty && bus_wr_en && bus_addr == A_HEAD0)
        |=> $stable(q_count));
endmodule

bind rp_intq rp_intq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .q_count   (q_count),
    .q_empty   (q_empty),
    .rd_ptr    (rd_ptr),
    .pend_intx (pend_intx),
    .ovf_flag  (ovf_flag),
    .intx_mask (intx_mask)
);

// File: tb/rp_intq_tb.sv
`timescale 1ns/1ps
module rp_intq_tb;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        evt_valid = 1'b0;
    logic [1:0]  evt_lane = '0;
    logic        evt_level = 1'b0;
    logic        link_up = 1'b0;
    logic        irq, bridge_en;

    always #2.5 clk = ~clk;   // 200 MHz

    rp_intq #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_valid(evt_valid),
        .evt_lane(evt_lane), .evt_level(evt_level), .link_up(link_up),
        .irq(irq), .bridge_en(bridge_en)
    );

    // behavioural reference state
    int          m_q[$];
    bit          m_pend, m_ovf, m_bren;
    bit [31:0]   m_mask;
    int          n_vec = 0, n_bad = 0;
    bit          done = 0;

    function automatic bit [31:0] model_read(bit [7:0] a);
        bit [31:0] v = '0;
        case (a)
            8'h4E: v[16] = m_pend;
            8'h4F: v = m_mask;
            8'h51: v[11] = link_up;
            8'h52: begin v[0] = m_bren; v[18] = (m_q.size() != 0); v[19] = m_ovf; end
            8'h56: if (m_q.size() != 0) begin
                       v[31] = 1'b1; v[29] = m_q[0][2]; v[28:27] = m_q[0][1:0];
                   end
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic string tag_of(bit [7:0] a);
        case (a)
            8'h4E: return "R7";
            8'h4F: return "R2";
            8'h51: return "R10";
            8'h52: return "R6/R5/R9";
            8'h56, 8'h57: return "R3/R4";
            default: return "R11";
        endcase
    endfunction

    task automatic check(string tag, bit [31:0] got, bit [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, update the model at the rising edge,
    // compare the outputs at the next falling edge.
    task automatic step(bit wr, bit [7:0] a, bit [31:0] d, bit ev, bit [1:0] ln, bit lv);
        bit full, pop, enq, clr;
        bus_wr_en = wr; bus_addr = a; bus_wdata = d;
        evt_valid = ev; evt_lane = ln; evt_level = lv;
        @(posedge clk);
        full = (m_q.size() == DEPTH - 1);
        pop  = wr && (a == 8'h56 || a == 8'h57) && m_q.size() != 0;
        enq  = ev && !full;
        clr  = wr && a == 8'h4E && d[16];
        if (wr && a == 8'h52 && d[19]) m_ovf = 0;
        if (ev && full) m_ovf = 1;
        if (pop) void'(m_q.pop_front());
        if (enq) m_q.push_back({29'b0, lv, ln});
        m_pend = (m_pend && !clr) || (m_q.size() != 0);
        if (wr && a == 8'h4F) m_mask = d;
        if (wr && a == 8'h52) m_bren = d[0];
        @(negedge clk);
        check("R8 irq", {31'b0, irq}, {31'b0, m_pend & m_mask[16]});
        check("R9 bridge_en", {31'b0, bridge_en}, {31'b0, m_bren});
        bus_wr_en = 0; evt_valid = 0;
    endtask

    task automatic rd(string tag, bit [7:0] a);
        bus_addr = a;
        #0.5;
        check({tag, " ", tag_of(a)}, bus_rdata, model_read(a));
    endtask

    task automatic sweep(string tag);
        rd(tag, 8'h4E); rd(tag, 8'h4F); rd(tag, 8'h51); rd(tag, 8'h52);
        rd(tag, 8'h56); rd(tag, 8'h57); rd(tag, 8'h00); rd(tag, 8'h50);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_pend = 0; m_ovf = 0; m_bren = 0; m_mask = '0;
        // R1: reset state
        sweep("R1 reset");
        check("R1 irq", {31'b0, irq}, 32'd0);

        // R2: mask readback, two patterns
        step(1, 8'h4F, 32'hFFFF_FFFF, 0, 0, 0); sweep("R2 mask ones");
        step(1, 8'h4F, 32'h0001_0000, 0, 0, 0); sweep("R2 mask intx");

        // R10: link bit follows the pin
        link_up = 1; sweep("R10 link up");

        // R3, R7, R8: one event then readout
        step(0, 0, 0, 1, 2'd2, 1); sweep("R3 one event");

        // R5: fill beyond capacity, flag set, extras dropped
        for (int i = 0; i < 9; i++) begin
            step(0, 0, 0, 1, 2'(i), 1'(i >> 1));
            sweep("R5 fill");
        end
        // R5: overflow and pop together, event still dropped
        step(1, 8'h56, 0, 1, 2'd3, 0); sweep("R5 full+pop");

        // R5: clear the flag
        step(1, 8'h52, 32'h0008_0000, 0, 0, 0); sweep("R5 ovf clear");

        // R7: clearing pending while entries remain has no lasting effect
        step(1, 8'h4E, 32'h0001_0000, 0, 0, 0); sweep("R7 clr busy");

        // R12: pop and enqueue together
        step(1, 8'h57, 32'h1234, 1, 2'd1, 1); sweep("R12 push+pop");

        // R4: drain in order through both head addresses
        for (int i = 0; i < 8; i++) begin
            step(1, (i % 2) ? 8'h57 : 8'h56, 32'hDEAD, 0, 0, 0);
            sweep("R4 drain");
        end
        // R4: pop when empty is ignored
        step(1, 8'h56, 0, 0, 0, 0); sweep("R4 empty pop");

        // R7: pending stays after drain, then clears
        sweep("R7 after drain");
        step(1, 8'h4E, 32'hFFFF_FFFF, 0, 0, 0); sweep("R7 clr empty");

        // R9: bridge enable set and cleared, flag clear does not touch it
        step(1, 8'h52, 32'h0000_0001, 0, 0, 0); sweep("R9 bren on");
        step(1, 8'h52, 32'h0000_0000, 0, 0, 0); sweep("R9 bren off");

        // R11: unmapped writes change nothing
        step(1, 8'h60, 32'hFFFF_FFFF, 0, 0, 0); sweep("R11 unmapped");
        link_up = 0; sweep("R10 link down");

        // R5: overflow set wins over clear in the same cycle
        for (int i = 0; i < 7; i++) step(0, 0, 0, 1, 2'd0, 0);
        step(1, 8'h52, 32'h0008_0000, 1, 2'd1, 1); sweep("R5 set wins");

        finish_run();
    end
endmodule